// File: doc/BRIEF.md
# Preemptive Fixed-Priority DMA Channel Arbiter

This block decides which of a group of DMA channels is served by a shared transfer engine. Every channel owns a one-byte priority register. The byte holds a 4-bit channel priority, a preemption-enable flag and a read-only mirror of the group priority. Among the channels that request service, the arbiter grants the one whose priority has the largest unsigned value. It reports the grant as a one-hot vector and as a channel index. The grant is held while the engine works through the channel.

The engine reports progress with two single-cycle pulses. `rw_done_i` marks the end of one read/write sequence. `minor_done_i` marks the end of the channel's minor loop and releases the grant. At a read/write boundary, a waiting channel with a higher priority and preemption enabled can suspend the running channel. The arbiter keeps one suspended channel. It restores that channel when the preempting channel completes its minor loop. The restored channel is then protected for one read/write sequence.

If software gives two channels the same priority, a configuration error is raised. While the error is raised, no new grants and no preemptions are issued.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, the priority field of channel n equals n, every preemption-enable bit is 0, no grant is active and `cfg_err_o` is low.
- R2: Priority byte layout. Bit 7 is preemption enable (read/write). Bit 6 always reads 0. Bits [5:4] read back `grp_prio_i`, and writes to them are ignored. Bits [3:0] are the channel priority (read/write). A write lands at the clock edge on which `reg_wr_en` is high, and reads are combinational.
- R3: When no grant is active and no configuration error is present, the requester with the numerically largest priority is granted at the next clock edge. `gnt_onehot_o` has only the bit for `gnt_idx_o` set.
- R4: While a grant is active, the grant is unchanged by request changes on every cycle without a `rw_done_i` or `minor_done_i` pulse.
- R5: `cfg_err_o` is high exactly while two channels hold the same priority value. While it is high, no grant starts from idle and no preemption occurs. It clears when the values are unique again.
- R6: On a `rw_done_i` pulse, the running channel is suspended and the grant moves to the highest other requester at that edge, provided that requester has a larger priority and its preemption-enable bit is set. A requester with a lower priority, or with the bit clear, causes no switch.
- R7: A channel that gained the grant by preemption is never preempted.
- R8: On `minor_done_i` from a preempting channel, the suspended channel is granted again at that edge, ahead of any other requester.
- R9: After a restore, the first `rw_done_i` pulse never preempts. Later pulses may preempt.
- R10: While `fixed_mode_i` is low, no preemption occurs.
- R11: `minor_done_i` with no suspended channel ends the grant at that edge. Arbitration from idle then resumes on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the priority byte at `reg_addr` |
| reg_addr | input | 4 | Channel whose priority byte is accessed |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected byte |
| grp_prio_i | input | 2 | Current group priority, mirrored into each byte |
| fixed_mode_i | input | 1 | High when both group and channel arbitration are fixed |
| req_i | input | 16 | Per-channel service requests |
| rw_done_i | input | 1 | Pulse: active channel finished one read/write sequence |
| minor_done_i | input | 1 | Pulse: active channel finished its minor loop |
| gnt_valid_o | output | 1 | A channel is granted |
| gnt_onehot_o | output | 16 | One-hot grant vector |
| gnt_idx_o | output | 4 | Index of granted channel |
| cfg_err_o | output | 1 | Duplicate priority detected |

## Verification
The properties assume that the engine pulses `rw_done_i` and `minor_done_i` only while a grant is active. They also assume the two pulses last a single cycle each. The stimulus follows these rules by raising either pulse for exactly one cycle, and only after a grant has been observed. The properties do not need requests to stay steady, because request changes between boundaries must never move the grant. The bench changes requests freely for that reason.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic [1:0] {
        ARB_HOLD,
        ARB_GRANT,
        ARB_PREEMPT,
        ARB_RESTORE
    } arb_act_e;

endpackage

// File: rtl/dma_prio_regs.sv
module dma_prio_regs #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned PRIO_W = 4,
    parameter int unsigned GRP_W  = 2,
    localparam int unsigned IDX_W  = $clog2(NUM_CH),
    localparam int unsigned BYTE_W = PRIO_W + GRP_W + 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               addr,
    input  logic [BYTE_W-1:0]              wdata,
    input  logic [GRP_W-1:0]               grp_prio,
    output logic [BYTE_W-1:0]              rdata,
    output logic [NUM_CH-1:0][PRIO_W-1:0]  pri_o,
    output logic [NUM_CH-1:0]              pre_en_o,
    output logic                           dup_err_o
);

    typedef struct packed {
        logic [NUM_CH-1:0][PRIO_W-1:0] pri;
        logic [NUM_CH-1:0]             pre_en;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (wr_en) begin
            rf_d.pri[addr]    = wdata[PRIO_W-1:0];
            rf_d.pre_en[addr] = wdata[BYTE_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                rf_q.pri[i] <= PRIO_W'(i);
            end
            rf_q.pre_en <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    // read path: enable, constant zero, group mirror, priority
    assign rdata = {rf_q.pre_en[addr], 1'b0, grp_prio, rf_q.pri[addr]};

    always_comb begin
        dup_err_o = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            for (int j = i + 1; j < NUM_CH; j++) begin
                if (rf_q.pri[i] == rf_q.pri[j]) dup_err_o = 1'b1;
            end
        end
    end

    assign pri_o    = rf_q.pri;
    assign pre_en_o = rf_q.pre_en;

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned PRIO_W = 4,
    localparam int unsigned IDX_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0]              req,
    input  logic [NUM_CH-1:0]              mask,
    input  logic [NUM_CH-1:0][PRIO_W-1:0]  pri,
    output logic                           found,
    output logic [IDX_W-1:0]               win_idx,
    output logic [PRIO_W-1:0]              win_pri
);

    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_pri = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (req[i] && !mask[i] && (!found || pri[i] > win_pri)) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
                win_pri = pri[i];
            end
        end
    end

endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned PRIO_W = 4,
    parameter int unsigned GRP_W  = 2,
    localparam int unsigned IDX_W  = $clog2(NUM_CH),
    localparam int unsigned BYTE_W = PRIO_W + GRP_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [IDX_W-1:0]  reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic [GRP_W-1:0]  grp_prio_i,
    input  logic              fixed_mode_i,
    input  logic [NUM_CH-1:0] req_i,
    input  logic              rw_done_i,
    input  logic              minor_done_i,
    output logic              gnt_valid_o,
    output logic [NUM_CH-1:0] gnt_onehot_o,
    output logic [IDX_W-1:0]  gnt_idx_o,
    output logic              cfg_err_o
);
    import dma_arb_pkg::*;

    typedef struct packed {
        logic             act_vld;
        logic [IDX_W-1:0] act_idx;
        logic             act_pre;
        logic             sus_vld;
        logic [IDX_W-1:0] sus_idx;
        logic             grace;
    } arb_t;

    arb_t s_d, s_q;

    logic [NUM_CH-1:0][PRIO_W-1:0] pri;
    logic [NUM_CH-1:0]             pre_en;
    logic                          dup_err;
    logic [NUM_CH-1:0]             act_mask;
    logic                          win_found;
    logic [IDX_W-1:0]              win_idx;
    logic [PRIO_W-1:0]             win_pri;
    logic                          preempt_ok;
    arb_act_e                      act;

    dma_prio_regs #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .GRP_W(GRP_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .grp_prio  (grp_prio_i),
        .rdata     (reg_rdata),
        .pri_o     (pri),
        .pre_en_o  (pre_en),
        .dup_err_o (dup_err)
    );

    assign act_mask = s_q.act_vld ? (NUM_CH'(1) << s_q.act_idx) : '0;

    dma_prio_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) i_pick (
        .req     (req_i),
        .mask    (act_mask),
        .pri     (pri),
        .found   (win_found),
        .win_idx (win_idx),
        .win_pri (win_pri)
    );

    assign preempt_ok = fixed_mode_i && !dup_err && !s_q.act_pre && !s_q.grace
                     && win_found && pre_en[win_idx] && (win_pri > pri[s_q.act_idx]);

    always_comb begin
        act = ARB_HOLD;
        s_d = s_q;
        if (s_q.act_vld) begin
            if (minor_done_i) begin
                if (s_q.sus_vld) begin
                    act = ARB_RESTORE;
                end else begin
                    s_d.act_vld = 1'b0;
                    s_d.act_pre = 1'b0;
                    s_d.grace   = 1'b0;
                end
            end else if (rw_done_i) begin
                if (preempt_ok) act = ARB_PREEMPT;
                s_d.grace = 1'b0;
            end
        end else if (win_found && !dup_err) begin
            act = ARB_GRANT;
        end

        case (act)
            ARB_GRANT: begin
                s_d.act_vld = 1'b1;
                s_d.act_idx = win_idx;
                s_d.act_pre = 1'b0;
                s_d.grace   = 1'b0;
            end
            ARB_PREEMPT: begin
                s_d.sus_vld = 1'b1;
                s_d.sus_idx = s_q.act_idx;
                s_d.act_idx = win_idx;
                s_d.act_pre = 1'b1;
            end
            ARB_RESTORE: begin
                s_d.act_idx = s_q.sus_idx;
                s_d.act_pre = 1'b0;
                s_d.sus_vld = 1'b0;
                s_d.grace   = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign gnt_valid_o  = s_q.act_vld;
    assign gnt_idx_o    = s_q.act_idx;
    assign gnt_onehot_o = act_mask;
    assign cfg_err_o    = dup_err;

endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
    parameter int unsigned NUM_CH = 16,
    localparam int unsigned IDX_W = $clog2(NUM_CH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fixed_mode_i,
    input logic             rw_done_i,
    input logic             minor_done_i,
    input logic             gnt_valid_o,
    input logic [IDX_W-1:0] gnt_idx_o,
    input logic             cfg_err_o
);

    // R4
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o && !rw_done_i && !minor_done_i |=> gnt_valid_o && gnt_idx_o == $past(gnt_idx_o));

    // R5
    no_idle_grant_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_valid_o && cfg_err_o |=> !gnt_valid_o);

    // R5
    no_preempt_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o && cfg_err_o && !minor_done_i |=> gnt_valid_o && gnt_idx_o == $past(gnt_idx_o));

    // R10
    no_preempt_unfixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o && !fixed_mode_i && !minor_done_i |=> gnt_valid_o && gnt_idx_o == $past(gnt_idx_o));

endmodule

bind dma_prio_arbiter dma_arb_chk #(.NUM_CH(NUM_CH)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fixed_mode_i (fixed_mode_i),
    .rw_done_i    (rw_done_i),
    .minor_done_i (minor_done_i),
    .gnt_valid_o  (gnt_valid_o),
    .gnt_idx_o    (gnt_idx_o),
    .cfg_err_o    (cfg_err_o)
);

// File: tb/test_dma_prio_arbiter.sv
module test_dma_prio_arbiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [1:0]  grp_prio_i = '0;
    logic        fixed_mode_i = 1'b1;
    logic [15:0] req_i = '0;
    logic        rw_done_i = 1'b0;
    logic        minor_done_i = 1'b0;
    logic        gnt_valid_o;
    logic [15:0] gnt_onehot_o;
    logic [3:0]  gnt_idx_o;
    logic        cfg_err_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    dma_prio_arbiter i_dma_prio_arbiter (.*);

    // {addr, wdata, grp, expected read, expected cfg_err}
    localparam logic [22:0] REG_VEC [0:6] = '{
        {4'd3,  8'h83, 2'b10, 8'hA3, 1'b0},
        {4'd4,  8'h74, 2'b01, 8'h14, 1'b0},
        {4'd7,  8'h07, 2'b11, 8'h37, 1'b0},
        {4'd0,  8'hB0, 2'b00, 8'h80, 1'b0},
        {4'd9,  8'h0A, 2'b00, 8'h0A, 1'b1},
        {4'd9,  8'h09, 2'b01, 8'h19, 1'b0},
        {4'd15, 8'h4F, 2'b10, 8'h2F, 1'b0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_gnt(string tag, logic vld, logic [3:0] idx);
        chk({tag, " valid"}, 32'(gnt_valid_o), 32'(vld));
        if (vld) chk({tag, " index"}, 32'(gnt_idx_o), 32'(idx));
        chk({tag, " onehot"}, 32'(gnt_onehot_o), vld ? (32'd1 << idx) : 32'd0);
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic rw_pulse();
        rw_done_i = 1'b1;
        tick();
        rw_done_i = 1'b0;
    endtask

    task automatic minor_pulse(logic [15:0] next_req);
        minor_done_i = 1'b1;
        req_i = next_req;
        tick();
        minor_done_i = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk_gnt("R1 idle after reset", 1'b0, 4'd0);
        chk("R1 cfg_err", 32'(cfg_err_o), 32'd0);
        for (int n = 0; n < 16; n += 5) begin
            reg_addr = 4'(n);
            #1;
            chk("R1 reset byte", 32'(reg_rdata), 32'(n));
        end

        // R2 / R5 register vectors
        for (int v = 0; v < 7; v++) begin
            grp_prio_i = REG_VEC[v][10:9];
            wr(REG_VEC[v][22:19], REG_VEC[v][18:11]);
            reg_addr = REG_VEC[v][22:19];
            #1;
            chk("R2 byte readback", 32'(reg_rdata), 32'(REG_VEC[v][8:1]));
            chk("R5 duplicate flag", 32'(cfg_err_o), 32'(REG_VEC[v][0]));
        end

        // R3 highest requester wins
        req_i = 16'h0224;
        tick();
        chk_gnt("R3 highest wins", 1'b1, 4'd9);

        // R4 stable under request changes
        req_i = 16'h4224;
        repeat (3) tick();
        chk_gnt("R4 held while busy", 1'b1, 4'd9);

        // R6 higher requester without enable bit
        rw_pulse();
        chk_gnt("R6 no enable no switch", 1'b1, 4'd9);

        // R6 preemption
        wr(4'd14, 8'h8E);
        rw_pulse();
        chk_gnt("R6 preempt to 14", 1'b1, 4'd14);

        // R7 preemptor not preemptible
        wr(4'd15, 8'h8F);
        req_i = 16'hC224;
        rw_pulse();
        chk_gnt("R7 no nested preempt", 1'b1, 4'd14);

        // R8 restore ahead of 15
        req_i = 16'h8224;
        minor_pulse(16'h8224);
        chk_gnt("R8 restore 9", 1'b1, 4'd9);

        // R9 grace then preempt
        rw_pulse();
        chk_gnt("R9 grace beat", 1'b1, 4'd9);
        rw_pulse();
        chk_gnt("R9 preempt after grace", 1'b1, 4'd15);
        minor_pulse(16'h0224);
        chk_gnt("R8 restore again", 1'b1, 4'd9);

        // R11 release and re-arbitrate
        minor_pulse(16'h0024);
        chk_gnt("R11 released", 1'b0, 4'd0);
        tick();
        chk_gnt("R11 next grant", 1'b1, 4'd5);

        // R6 lower-priority enabled requester ignored
        req_i = 16'h0025;
        rw_pulse();
        chk_gnt("R6 lower no switch", 1'b1, 4'd5);
        minor_pulse(16'h0000);
        chk_gnt("R11 idle", 1'b0, 4'd0);

        // R10 non-fixed mode
        req_i = 16'h0200;
        tick();
        chk_gnt("R10 grant 9", 1'b1, 4'd9);
        fixed_mode_i = 1'b0;
        req_i = 16'h8200;
        rw_pulse();
        chk_gnt("R10 no preempt unfixed", 1'b1, 4'd9);
        fixed_mode_i = 1'b1;
        rw_pulse();
        chk_gnt("R10 preempt when fixed", 1'b1, 4'd15);
        minor_pulse(16'h0200);
        minor_pulse(16'h0000);
        chk_gnt("R11 idle again", 1'b0, 4'd0);

        // R5 error blocks idle grant
        wr(4'd1, 8'h02);
        chk("R5 dup raised", 32'(cfg_err_o), 32'd1);
        req_i = 16'h0004;
        repeat (2) tick();
        chk_gnt("R5 no grant on error", 1'b0, 4'd0);
        wr(4'd1, 8'h01);
        chk("R5 dup cleared", 32'(cfg_err_o), 32'd0);
        tick();
        chk_gnt("R5 grant after fix", 1'b1, 4'd2);

        // R5 error blocks preemption
        wr(4'd1, 8'h03);
        req_i = 16'h000C;
        rw_pulse();
        chk_gnt("R5 no preempt on error", 1'b1, 4'd2);
        wr(4'd1, 8'h01);
        rw_pulse();
        chk_gnt("R6 preempt to 3", 1'b1, 4'd3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule